// File: doc/BRIEF.md
# Floating-Point Status and Exception Register

This block is the control and status register beside a floating-point datapath. Software writes a rounding-mode field, a denormal flush control and a five-bit trap-enable mask. The arithmetic unit reports its IEEE exception flags each time it finishes an operation. The flags are invalid (V), divide-by-zero (Z), overflow (O), underflow (U) and inexact (I).

Each time an operation completes, the register clears the per-operation cause field and loads it with the new flags. It then ORs those flags into a sticky accumulated field. Only a software write clears the sticky field. If any new cause bit meets a set enable bit, the block issues a one-cycle exception request that carries a fixed vector code.

An operation can be marked as an approximate reciprocal square root. If such an operation reports no flags, the block forces inexact on. The block also decodes the rounding-mode field and the flush control into two control lines for the datapath.

Top module: `fpsr_unit`

## Requirements
- R1: After reset, csr_o is 0, exc_req_o and exc_code_o are 0, round_zero_o is 0 and flush_zero_o is 0.
- R2: A write with wr_en_i stores wr_data_i AND 0x0005FFFF. The stored value appears on csr_o in the following cycle. Bits 17 and 19 to 31 always read 0.
- R3: When op_done_i is high, the cause field csr_o[16:12] is replaced by the operation's flags. op_flags_i and every 5-bit field use the order {V,Z,O,U,I}, with V in the field's top bit and I in its lowest bit.
- R4: On every completed operation, the new cause bits are ORed into the sticky field csr_o[6:2]. An operation never clears a sticky bit.
- R5: A completed operation that reports no flags (and is not a reciprocal square root) clears the cause field, leaves the sticky field unchanged and raises no request.
- R6: exc_req_o is high for exactly the cycle after an operation whose new cause ANDed with the enable field csr_o[11:7] is nonzero. While exc_req_o is high, exc_code_o is 0x120; otherwise it is 0.
- R7: round_zero_o is 1 exactly when csr_o[1:0] is 2'b01 (truncate). Every other encoding selects round-to-nearest-even (round_zero_o = 0).
- R8: flush_zero_o follows csr_o[18].
- R9: An operation with op_rsqrt_i high and no flags is treated as flags 5'b00001 (inexact only). If it reports any flag, those flags pass unchanged.
- R10: If a write and a completed operation fall in the same cycle, the masked write value is taken first and the operation's cause and sticky update is applied on top. The exception test uses the enable field from the written value.
- R11: When neither wr_en_i nor op_done_i is high, csr_o holds its value. op_flags_i and op_rsqrt_i are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data, masked before storage |
| op_done_i | input | 1 | Arithmetic operation completed this cycle |
| op_flags_i | input | 5 | Operation exception flags {V,Z,O,U,I} |
| op_rsqrt_i | input | 1 | Completed operation is an approximate reciprocal square root |
| csr_o | output | 32 | Register contents |
| round_zero_o | output | 1 | 1 selects truncation, 0 selects round-to-nearest-even |
| flush_zero_o | output | 1 | Flush denormals to zero |
| exc_req_o | output | 1 | One-cycle exception request |
| exc_code_o | output | 12 | Exception vector code while requesting, else 0 |

## Verification
The assertions take for granted that op_flags_i and op_rsqrt_i matter only in a cycle with op_done_i, and that a write can arrive in any cycle. They also assume back-to-back operations are legal, so a request may stay high across consecutive cycles. The stimulus covers this by driving random flags and rsqrt marks in idle cycles as well. It mixes writes, operations and coincident write-plus-operation cycles at random, and adds directed cases for each enable bit, the truncate encoding and the forced-inexact rule.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int unsigned NEXC    = 5;
  localparam int unsigned CSR_W   = 32;
  localparam int unsigned RM_W    = 2;
  localparam int unsigned RM_LSB  = 0;
  localparam int unsigned FLG_LSB = RM_LSB + RM_W;
  localparam int unsigned EN_LSB  = FLG_LSB + NEXC;
  localparam int unsigned CAU_LSB = EN_LSB + NEXC;
  localparam int unsigned DN_BIT  = CAU_LSB + NEXC + 1;
  localparam int unsigned INX_BIT = 0;
  localparam logic [CSR_W-1:0] WR_MASK  = 32'h0005_FFFF;
  localparam logic [RM_W-1:0]  RM_TRUNC = 2'b01;

  typedef logic [NEXC-1:0]  exc_vec_t;
  typedef logic [CSR_W-1:0] csr_t;
endpackage

// File: rtl/fpsr_cause.sv
module fpsr_cause
  import fpsr_pkg::*;
(
  input  exc_vec_t flags_i,
  input  logic     rsqrt_i,
  output exc_vec_t cause_o
);
  // approximate result: inexact unless something else was reported
  always_comb begin
    cause_o = flags_i;
    if (rsqrt_i && (flags_i == '0)) cause_o[INX_BIT] = 1'b1;
  end
endmodule

// File: rtl/fpsr_regs.sv
module fpsr_regs
  import fpsr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_en_i,
  input  csr_t     wr_data_i,
  input  logic     op_done_i,
  input  exc_vec_t cause_i,
  output csr_t     csr_o,
  output logic     exc_o
);
  csr_t csr_q, csr_d;
  logic exc_d, exc_q;

  always_comb begin
    csr_d = wr_en_i ? (wr_data_i & WR_MASK) : csr_q;
    exc_d = 1'b0;
    if (op_done_i) begin
      csr_d[CAU_LSB +: NEXC] = cause_i;
      csr_d[FLG_LSB +: NEXC] = csr_d[FLG_LSB +: NEXC] | cause_i;
      exc_d = |(cause_i & csr_d[EN_LSB +: NEXC]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q <= '0;
      exc_q <= 1'b0;
    end else begin
      csr_q <= csr_d;
      exc_q <= exc_d;
    end
  end

  assign csr_o = csr_q;
  assign exc_o = exc_q;
endmodule

// File: rtl/fpsr_ctrl.sv
module fpsr_ctrl
  import fpsr_pkg::*;
(
  input  csr_t csr_i,
  output logic round_zero_o,
  output logic flush_zero_o
);
  assign round_zero_o = (csr_i[RM_LSB +: RM_W] == RM_TRUNC);
  assign flush_zero_o = csr_i[DN_BIT];
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
  import fpsr_pkg::*;
#(
  parameter int unsigned  CODE_W   = 12,
  parameter logic [CODE_W-1:0] VEC_CODE = 12'h120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic              op_done_i,
  input  logic [4:0]        op_flags_i,
  input  logic              op_rsqrt_i,
  output logic [31:0]       csr_o,
  output logic              round_zero_o,
  output logic              flush_zero_o,
  output logic              exc_req_o,
  output logic [CODE_W-1:0] exc_code_o
);
  exc_vec_t cause;

  fpsr_cause u_cause (
    .flags_i (op_flags_i),
    .rsqrt_i (op_rsqrt_i),
    .cause_o (cause)
  );

  fpsr_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .op_done_i (op_done_i),
    .cause_i   (cause),
    .csr_o     (csr_o),
    .exc_o     (exc_req_o)
  );

  fpsr_ctrl u_ctrl (
    .csr_i        (csr_o),
    .round_zero_o (round_zero_o),
    .flush_zero_o (flush_zero_o)
  );

  assign exc_code_o = exc_req_o ? VEC_CODE : '0;
endmodule

// File: rtl/fpsr_unit_chk.sv
module fpsr_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic        op_done_i,
  input logic [4:0]  op_flags_i,
  input logic        op_rsqrt_i,
  input logic [31:0] csr_o,
  input logic        round_zero_o,
  input logic        flush_zero_o,
  input logic        exc_req_o,
  input logic [11:0] exc_code_o
);
  // R6
  req_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> exc_code_o == 12'h120);
  // R6
  idle_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_req_o |-> exc_code_o == 12'h000);
  // R6
  req_after_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exc_req_o) |-> $past(op_done_i));
  // R4
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((csr_o[6:2] & $past(csr_o[6:2])) == $past(csr_o[6:2])));
  // R11
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !op_done_i) |=> $stable(csr_o));
  // R5
  no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i && !wr_en_i && !op_rsqrt_i && op_flags_i == 5'd0)
      |=> (csr_o[16:12] == 5'd0 && !exc_req_o && $stable(csr_o[6:2])));
  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_o[31:19] == 13'd0 && !csr_o[17]);
  // R7
  round_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    round_zero_o == (csr_o[1:0] == 2'b01));
  // R8
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_zero_o == csr_o[18]);
endmodule

bind fpsr_unit fpsr_unit_chk u_chk (.*);

// File: tb/fpsr_unit_test.sv
`timescale 1ns/1ps
module fpsr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        op_done = 1'b0;
  logic [4:0]  op_flags = '0;
  logic        op_rsqrt = 1'b0;
  logic [31:0] csr;
  logic        rnd_z, fl_z, exc_req;
  logic [11:0] exc_code;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_csr = '0;
  logic        m_exc = 1'b0;

  always #10 clk = ~clk;

  fpsr_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .op_done_i(op_done), .op_flags_i(op_flags), .op_rsqrt_i(op_rsqrt),
    .csr_o(csr), .round_zero_o(rnd_z), .flush_zero_o(fl_z),
    .exc_req_o(exc_req), .exc_code_o(exc_code)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt_csr(logic [31:0] cur, logic wr, logic [31:0] d,
                                          logic op, logic [4:0] f, logic rs);
    logic [31:0] b;
    logic [4:0]  c;
    b = wr ? (d & 32'h0005_FFFF) : cur;
    c = (rs && f == 5'd0) ? 5'b00001 : f;
    if (op) begin
      b[16:12] = c;
      b[6:2]   = b[6:2] | c;
    end
    return b;
  endfunction

  function automatic logic nxt_exc(logic [31:0] cur, logic wr, logic [31:0] d,
                                   logic op, logic [4:0] f, logic rs);
    logic [31:0] b;
    logic [4:0]  c;
    b = wr ? (d & 32'h0005_FFFF) : cur;
    c = (rs && f == 5'd0) ? 5'b00001 : f;
    return op && ((c & b[11:7]) != 5'd0);
  endfunction

  task automatic step(input string tag, input logic wr, input logic [31:0] d,
                      input logic op, input logic [4:0] f, input logic rs);
    wr_en = wr; wr_data = d; op_done = op; op_flags = f; op_rsqrt = rs;
    @(posedge clk);
    m_exc = nxt_exc(m_csr, wr, d, op, f, rs);
    m_csr = nxt_csr(m_csr, wr, d, op, f, rs);
    @(negedge clk);
    wr_en = 1'b0; op_done = 1'b0;
    op_flags = 5'($urandom); op_rsqrt = 1'($urandom);
    check(tag, csr, m_csr);
    check("R6 req", {31'd0, exc_req}, {31'd0, m_exc});
    check("R6 code", {20'd0, exc_code}, m_exc ? 32'h120 : 32'h0);
    check("R7 round", {31'd0, rnd_z}, {31'd0, m_csr[1:0] == 2'b01});
    check("R8 flush", {31'd0, fl_z}, {31'd0, m_csr[18]});
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1
    check("R1 csr", csr, 32'h0);
    check("R1 req", {31'd0, exc_req}, 32'h0);
    check("R1 code", {20'd0, exc_code}, 32'h0);
    check("R1 round", {31'd0, rnd_z}, 32'h0);
    check("R1 flush", {31'd0, fl_z}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 masked write
    step("R2", 1'b1, 32'hFFFF_FFFF, 1'b0, 5'd0, 1'b0);
    check("R2 value", csr, 32'h0005_FFFF);
    step("R2", 1'b1, 32'h0, 1'b0, 5'd0, 1'b0);
    // R7 every rounding encoding
    for (int k = 0; k < 4; k++) step("R7", 1'b1, 32'(k), 1'b0, 5'd0, 1'b0);
    // R8
    step("R8", 1'b1, 32'h0004_0000, 1'b0, 5'd0, 1'b0);
    step("R8", 1'b1, 32'h0, 1'b0, 5'd0, 1'b0);
    // R3 / R4 cause replace and sticky accumulate
    step("R3", 1'b0, 32'h0, 1'b1, 5'b10000, 1'b0);
    check("R3 cause V", csr, 32'h0001_0040);
    step("R4", 1'b0, 32'h0, 1'b1, 5'b00010, 1'b0);
    check("R4 sticky V|U", csr, 32'h0000_2048);
    // R5 no flags
    step("R5", 1'b0, 32'h0, 1'b1, 5'd0, 1'b0);
    check("R5 cleared cause", csr, 32'h0000_0048);
    // R11 flags without completion
    step("R11", 1'b0, 32'h0, 1'b0, 5'b11111, 1'b1);
    check("R11 unchanged", csr, 32'h0000_0048);
    // R9 forced inexact, and pass-through when flags present
    step("R9", 1'b1, 32'h0, 1'b1, 5'd0, 1'b1);
    check("R9 forced I", csr, 32'h0000_1004);
    step("R9", 1'b0, 32'h0, 1'b1, 5'b00100, 1'b1);
    check("R9 O only", csr, 32'h0000_4014);
    // R6 enabled Z, then disabled-only cause, then idle
    step("R6", 1'b1, 32'h0000_0400, 1'b0, 5'd0, 1'b0);
    step("R6", 1'b0, 32'h0, 1'b1, 5'b01000, 1'b0);
    check("R6 pulse", {31'd0, exc_req}, 32'h1);
    step("R6", 1'b0, 32'h0, 1'b0, 5'd0, 1'b0);
    check("R6 drop", {31'd0, exc_req}, 32'h0);
    step("R6", 1'b0, 32'h0, 1'b1, 5'b00100, 1'b0);
    check("R6 masked", {31'd0, exc_req}, 32'h0);
    // R10 write enabling V together with a V operation
    step("R10", 1'b1, 32'h0000_0800, 1'b1, 5'b10000, 1'b0);
    check("R10 req", {31'd0, exc_req}, 32'h1);
    check("R10 csr", csr, 32'h0001_0840);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom;
      if ($urandom_range(0, 3) == 0) d[6:2] = 5'd0;
      step("R3 rnd", ($urandom_range(0, 4) == 0), d, 1'($urandom),
           ($urandom_range(0, 2) == 0) ? 5'd0 : 5'($urandom), 1'($urandom));
    end
    finish_run();
  end
endmodule